// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block decides when an SDRAM controller must spend a cycle slot on an auto-refresh. A programmable interval sets how many clock cycles separate refreshes. A down-counter measures each interval. When it runs out, a refresh is owed and the block raises a request to the command issuer. The issuer acknowledges the request when it starts the refresh sequence and reports completion when the sequence ends. The block supplies no row address, because the memory device keeps its own refresh row pointer.

A refresh never cuts into a data burst. While the datapath reports a burst in flight, the request stays low, and it rises as soon as the burst ends. From the moment a refresh is owed until its command sequence has finished, the block drives a busy flag towards the host side, so that new accesses are stalled there and are not delayed silently inside the controller. Expiries that occur while an earlier refresh is still owed are kept in a small saturating backlog, so refreshes held back by long bursts are served later. An interval of zero switches refresh generation off.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ref_req_o` and `busy_o` are low.
- R2: With a nonzero interval N, the timer loads N on the first clock edge on which it is enabled: after reset, or when the interval changes from zero. The first refresh request is raised N edges after that load edge.
- R3: A request is accepted on an edge where `ref_req_o` and `ref_ack_i` are both high. That edge reloads the timer with N, so the next request rises N edges after the acceptance edge. The request is low in the cycle after acceptance.
- R4: `ref_req_o` is never high while `burst_active_i` is high. When a refresh is owed, it rises in the same cycle that `burst_active_i` falls.
- R5: `busy_o` is high whenever a refresh is owed or a refresh sequence is running. It goes low in the cycle after the edge that samples `ref_done_i` high, provided no further refresh is owed.
- R6: An interval of zero clears the timer. No expiry happens while the interval is zero. Enabling the interval again starts a full interval.
- R7: Expiries that occur before earlier refreshes are accepted are counted, up to MAX_PEND (3 by default). Further expiries are dropped. Each acceptance serves exactly one counted refresh.
- R8: `ref_ack_i` has no effect while `ref_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interval_i | input | CNT_W | Clock cycles between refreshes; 0 disables generation |
| burst_active_i | input | 1 | Datapath burst in flight; holds the request off |
| ref_ack_i | input | 1 | Command issuer accepts the refresh request |
| ref_done_i | input | 1 | Command issuer finished the refresh sequence |
| ref_req_o | output | 1 | Refresh request to the command issuer |
| busy_o | output | 1 | Host-side stall while a refresh is owed or running |

## Verification
A wrong timer value shows up as a request that rises early or late, so the bench counts edges exactly from reset release, from acceptance and from re-enabling. A backlog counter that does not saturate, or that loses counts, shows up later: the number of refreshes served after a long burst is wrong. This only becomes visible after the burst ends and the bench drains the backlog. A phase register stuck in the running state keeps `busy_o` high past the cycle after `ref_done_i`, and a stale request while a burst runs is visible in the same cycle.

// File: rtl/refresh_sched_pkg.sv
// Shared types for the refresh scheduler.
package refresh_sched_pkg;
    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } ref_phase_t;
endpackage

// File: rtl/refresh_timer.sv
// Interval down-counter. Loads the interval on its first enabled edge.
// Reloads on every expiry and on every accepted refresh.
// Assumes interval_i is held steady, apart from deliberate changes.
// A value of zero parks the counter at zero, and then nothing expires.
module refresh_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             reload_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             enabled;

    assign enabled = (interval_i != '0);

    // Expiry is raised while the count shows one, unless an acceptance restarts the interval.
    assign expire_o = enabled && (cnt_q == ONE) && !reload_i;

    // Count down, reload on acceptance or expiry, and park at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enabled) begin
            cnt_q <= '0;
        end else if (reload_i || cnt_q == '0 || cnt_q == ONE) begin
            cnt_q <= interval_i;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/refresh_backlog.sv
// Saturating count of refreshes that are owed but not yet accepted.
// It assumes dec_i is high only while the count is nonzero.
module refresh_backlog #(
    parameter int MAX_PEND = 3,
    parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              owed_o
);
    localparam int SUM_W = PEND_W + 1;
    localparam logic [SUM_W-1:0] CAP = SUM_W'(MAX_PEND);

    logic [PEND_W-1:0] pend_q;
    logic [SUM_W-1:0]  sum;

    // Next count before saturation.
    always_comb begin
        sum = {1'b0, pend_q} + SUM_W'(inc_i) - SUM_W'(dec_i);
    end

    // Hold the owed count, capped at MAX_PEND.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (sum > CAP) begin
            pend_q <= CAP[PEND_W-1:0];
        end else begin
            pend_q <= sum[PEND_W-1:0];
        end
    end

    assign pend_o = pend_q;
    assign owed_o = (pend_q != '0);
endmodule

// File: rtl/refresh_handshake.sv
// Request and acceptance handshake with the command issuer.
// The request is offered only while idle, while a refresh is owed and while no burst runs.
// The issuer is assumed to pulse done once per accepted refresh.
module refresh_handshake
    import refresh_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic owed_i,
    input  logic burst_i,
    input  logic ack_i,
    input  logic done_i,
    output logic req_o,
    output logic accept_o,
    output logic active_o
);
    ref_phase_t phase_q;

    // The request is offered only while idle and with no burst in flight.
    assign req_o    = owed_i && !burst_i && (phase_q == PH_IDLE);
    assign accept_o = req_o && ack_i;
    assign active_o = (phase_q == PH_ACTIVE);

    // Track whether a refresh sequence is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:   if (accept_o) phase_q <= PH_ACTIVE;
                PH_ACTIVE: if (done_i)   phase_q <= PH_IDLE;
                default:                 phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/refresh_sched.sv
// Top level of the refresh scheduler. Connects the timer, the owed-refresh count and the handshake.
// Busy covers every cycle from the first owed refresh to the end of its sequence.
module refresh_sched #(
    parameter int CNT_W    = 16,
    parameter int MAX_PEND = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             burst_active_i,
    input  logic             ref_ack_i,
    input  logic             ref_done_i,
    output logic             ref_req_o,
    output logic             busy_o
);
    localparam int PEND_W = $clog2(MAX_PEND + 1);

    logic              expire;
    logic              accept;
    logic              owed;
    logic              active;
    logic [PEND_W-1:0] pend_q;

    refresh_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .interval_i (interval_i),
        .reload_i   (accept),
        .expire_o   (expire)
    );

    refresh_backlog #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (expire),
        .dec_i  (accept),
        .pend_o (pend_q),
        .owed_o (owed)
    );

    refresh_handshake u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .owed_i   (owed),
        .burst_i  (burst_active_i),
        .ack_i    (ref_ack_i),
        .done_i   (ref_done_i),
        .req_o    (ref_req_o),
        .accept_o (accept),
        .active_o (active)
    );

    // Host stall: a refresh is owed or its sequence is still running.
    assign busy_o = owed || active;
endmodule

// File: rtl/refresh_sched_chk.sv
// Temporal checks on the refresh scheduler, attached by bind.
module refresh_sched_chk #(
    parameter int CNT_W    = 16,
    parameter int MAX_PEND = 3,
    parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] interval_i,
    input logic             burst_active_i,
    input logic             ref_ack_i,
    input logic             ref_done_i,
    input logic             ref_req_o,
    input logic             busy_o,
    input logic [PEND_W-1:0] pend_q
);
    assert_no_req_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> !burst_active_i);

    assert_req_drop_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && ref_ack_i) |=> !ref_req_o);

    assert_busy_covers_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> busy_o);

    assert_busy_fall_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(ref_done_i));

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_i == '0 && !busy_o) |=> !busy_o);

    assert_backlog_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_q) <= MAX_PEND);
endmodule

bind refresh_sched refresh_sched_chk #(
    .CNT_W(CNT_W), .MAX_PEND(MAX_PEND), .PEND_W(PEND_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .interval_i     (interval_i),
    .burst_active_i (burst_active_i),
    .ref_ack_i      (ref_ack_i),
    .ref_done_i     (ref_done_i),
    .ref_req_o      (ref_req_o),
    .busy_o         (busy_o),
    .pend_q         (pend_q)
);

// File: tb/refresh_sched_tb.sv
// Directed bench for the refresh scheduler: one task for each scenario.
module refresh_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] interval_i = '0;
    logic             burst_active_i = 1'b0;
    logic             ref_ack_i = 1'b0;
    logic             ref_done_i = 1'b0;
    logic             ref_req_o;
    logic             busy_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_sched #(.CNT_W(CNT_W), .MAX_PEND(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .interval_i(interval_i),
        .burst_active_i(burst_active_i), .ref_ack_i(ref_ack_i),
        .ref_done_i(ref_done_i), .ref_req_o(ref_req_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Advance one edge and settle.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input int iv);
        @(negedge clk);
        rst_n = 1'b0; interval_i = CNT_W'(iv);
        burst_active_i = 0; ref_ack_i = 0; ref_done_i = 0;
        tick(); tick();
        @(negedge clk); rst_n = 1'b1;
    endtask

    // Wait for a request, accept it, then finish the sequence two edges later.
    task automatic serve(output bit got);
        got = 0;
        for (int i = 0; i < 20 && !ref_req_o; i++) tick();
        if (ref_req_o) begin
            got = 1;
            @(negedge clk); ref_ack_i = 1;
            tick(); ref_ack_i = 0;
            tick();
            @(negedge clk); ref_done_i = 1;
            tick(); ref_done_i = 0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 0; interval_i = 16'd5;
        tick();
        chk(ref_req_o == 0, "R1 req in reset", ref_req_o, 0);
        chk(busy_o == 0, "R1 busy in reset", busy_o, 0);
        @(negedge clk); rst_n = 1;
        tick();
        chk(ref_req_o == 0 && busy_o == 0, "R1 first cycle out", {ref_req_o, busy_o}, 0);
    endtask

    task automatic t_first_interval();
        int edges = 0;
        do_reset(7);
        while (!ref_req_o && edges < 50) begin tick(); edges++; end
        chk(edges == 8, "R2 first request edge", edges, 8);
    endtask

    task automatic t_reload_on_accept();
        int edges = 0;
        do_reset(10);
        while (!ref_req_o) tick();
        @(negedge clk); ref_ack_i = 1;
        tick(); ref_ack_i = 0;
        chk(ref_req_o == 0, "R3 req low after accept", ref_req_o, 0);
        while (edges < 50) begin
            tick(); edges++;
            if (edges == 2) ref_done_i = 1;
            if (edges == 3) ref_done_i = 0;
            if (ref_req_o) break;
        end
        chk(edges == 10, "R3 next request edge", edges, 10);
    endtask

    task automatic t_burst_holdoff();
        do_reset(5);
        @(negedge clk); burst_active_i = 1;
        repeat (20) tick();
        chk(ref_req_o == 0, "R4 req during burst", ref_req_o, 0);
        chk(busy_o == 1, "R5 busy while owed", busy_o, 1);
        @(negedge clk); burst_active_i = 0;
        #1;
        chk(ref_req_o == 1, "R4 req when burst ends", ref_req_o, 1);
    endtask

    task automatic t_busy_release();
        do_reset(12);
        while (!ref_req_o) tick();
        @(negedge clk); ref_ack_i = 1;
        tick(); ref_ack_i = 0;
        tick();
        chk(busy_o == 1, "R5 busy during sequence", busy_o, 1);
        ref_done_i = 1;
        tick(); ref_done_i = 0;
        chk(busy_o == 0, "R5 busy drop after done", busy_o, 0);
    endtask

    task automatic t_disabled();
        int seen = 0;
        int edges = 0;
        do_reset(0);
        repeat (60) begin tick(); seen += int'(ref_req_o) + int'(busy_o); end
        chk(seen == 0, "R6 zero interval quiet", seen, 0);
        @(negedge clk); interval_i = 16'd8;
        repeat (5) tick();
        @(negedge clk); interval_i = 16'd0;
        repeat (20) begin tick(); seen += int'(ref_req_o); end
        chk(seen == 0, "R6 disable mid count", seen, 0);
        @(negedge clk); interval_i = 16'd8;
        while (!ref_req_o && edges < 50) begin tick(); edges++; end
        chk(edges == 9, "R6 full interval after enable", edges, 9);
    endtask

    task automatic t_backlog();
        int served = 0;
        bit got;
        do_reset(4);
        @(negedge clk); burst_active_i = 1;
        repeat (40) tick();
        @(negedge clk); interval_i = 16'd0; burst_active_i = 0;
        for (int k = 0; k < 6; k++) begin
            serve(got);
            if (got) served++;
        end
        chk(served == 3, "R7 backlog served count", served, 3);
        chk(busy_o == 0, "R7 busy after drain", busy_o, 0);
    endtask

    task automatic t_stray_ack();
        int edges = 0;
        do_reset(0);
        @(negedge clk); ref_ack_i = 1;
        tick(); ref_ack_i = 0;
        tick();
        chk(busy_o == 0 && ref_req_o == 0, "R8 stray ack idle", {busy_o, ref_req_o}, 0);
        @(negedge clk); interval_i = 16'd6;
        while (!ref_req_o && edges < 50) begin tick(); edges++; end
        chk(edges == 7, "R8 timing after stray ack", edges, 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_first_interval();
        t_reload_on_accept();
        t_burst_holdoff();
        t_busy_release();
        t_disabled();
        t_backlog();
        t_stray_ack();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule